// File: doc/BRIEF.md
# Mode-0 Parallel I/O Port

This block is a bus-attached parallel I/O peripheral with three byte-wide ports, named A, B and C. A small CPU-side register interface uses a chip select, a 2-bit register offset, read and write strobes and separate write and read data buses. Through this interface software writes port data and a single encoded control word. The control word sets the direction of port A, of port B, and of each half of port C.

Each port on the pin side has an input bus, an output bus and a per-bit output enable, so the pads or an external tristate stage can be attached directly. Only basic input/output operation is accepted. Control words that ask for strobed or bidirectional operation are dropped, and so are control words without the mode-set flag. Inputs are synchronized before software can read them. Output bits read back from their latches.

Top module: `pio3_port`

## Requirements
- R1: After reset the control register reads 0x9B, every output enable is low and every output latch is 0.
- R2: Offset 0 selects port A, offset 1 port B, offset 2 port C and offset 3 the control word, for both reads and writes.
- R3: A control write is accepted when bit 7 is 1, bits 6:5 are 00 and bit 2 is 0. After it is accepted, bit 4 gives the direction of port A, bit 1 of port B, bit 3 of port C bits 7:4 and bit 0 of port C bits 3:0, with 1 meaning input. The output enables of each group are the inverse of its direction bit, and the control word reads back unchanged.
- R4: A control write with bit 7 = 0 changes nothing: the control readback, the output enables and the latches all keep their values.
- R5: A control write with bit 7 = 1 that requests a non-basic mode (bits 6:5 not 00, or bit 2 set) is ignored completely.
- R6: An accepted control write clears all three output latches to 0 on the same clock edge.
- R7: A port write takes effect on the clock edge where chip select and write are both high. The port's output bus then carries the written value, and a read of an output port returns its latch.
- R8: A read of an input bit returns that pin's value after a two-flop synchronizer. A pin change becomes visible on the second rising clock edge after it.
- R9: With port C split, only the output nibble has its enables high, and a port C read combines the input nibble's pins with the output nibble's latch.
- R10: A write to a port that is set as input updates its latch but does not drive the pins. A later mode-set that switches it to output presents 0.
- R11: The read data bus is 0 whenever chip select and read are not both high.
- R12: A write strobe without chip select changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select |
| addr_i | input | 2 | Register offset |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| pa_i | input | 8 | Port A pin inputs |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 8 | Port A output enables |
| pb_i | input | 8 | Port B pin inputs |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 8 | Port B output enables |
| pc_i | input | 8 | Port C pin inputs |
| pc_o | output | 8 | Port C output latch |
| pc_oe_o | output | 8 | Port C output enables |

## Verification
If the control register is corrupted, the fault shows up on the output enables in the cycle right after the write. It can also be seen on the control readback, with no further delay. A latch that is not cleared or not loaded shows on its port output bus one edge after the write strobe. A synchronizer stage that is missing or extra moves the first cycle in which a changed pin appears on the read bus by one edge. The bench therefore samples reads at exact edge counts after each pin change.

// File: rtl/pio3_pkg.sv
package pio3_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 2;

  typedef enum logic [AW-1:0] {
    REG_PA  = 2'd0,
    REG_PB  = 2'd1,
    REG_PC  = 2'd2,
    REG_CTL = 2'd3
  } reg_sel_e;

  // control word bit positions
  localparam int unsigned CTL_CLO = 0;
  localparam int unsigned CTL_PB  = 1;
  localparam int unsigned CTL_GBM = 2;
  localparam int unsigned CTL_CHI = 3;
  localparam int unsigned CTL_PA  = 4;
  localparam int unsigned CTL_GAL = 5;
  localparam int unsigned CTL_GAH = 6;
  localparam int unsigned CTL_SET = 7;

  localparam logic [DW-1:0] CTL_RESET = 8'h9B;

  typedef struct packed {
    logic pa_in;
    logic pb_in;
    logic chi_in;
    logic clo_in;
  } dir_t;

  function automatic logic ctl_valid(input logic [DW-1:0] w);
    return w[CTL_SET] && !w[CTL_GAH] && !w[CTL_GAL] && !w[CTL_GBM];
  endfunction

  function automatic dir_t ctl_dirs(input logic [DW-1:0] w);
    dir_t d;
    d.pa_in  = w[CTL_PA];
    d.pb_in  = w[CTL_PB];
    d.chi_in = w[CTL_CHI];
    d.clo_in = w[CTL_CLO];
    return d;
  endfunction
endpackage

// File: rtl/pio3_sync.sv
module pio3_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pio3_ctrl.sv
module pio3_ctrl
  import pio3_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ctl_o,
  output dir_t          dir_o,
  output logic          accept_o
);
  logic [DW-1:0] ctl_q;

  assign accept_o = we_i && ctl_valid(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ctl_q <= CTL_RESET;
    else if (accept_o) ctl_q <= wdata_i;
  end

  assign ctl_o = ctl_q;
  assign dir_o = ctl_dirs(ctl_q);
endmodule

// File: rtl/pio3_lane.sv
module pio3_lane #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic         dir_in_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] latch_q;
  logic [W-1:0] pin_s;

  pio3_sync #(.W(W), .STAGES(2)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  // mode-set clear wins; both never coincide on one offset anyway
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    latch_q <= '0;
    else if (clr_i) latch_q <= '0;
    else if (we_i)  latch_q <= wdata_i;
  end

  assign pin_o   = latch_q;
  assign oe_o    = {W{~dir_in_i}};
  assign rdata_o = dir_in_i ? pin_s : latch_q;
endmodule

// File: rtl/pio3_port.sv
module pio3_port
  import pio3_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] pa_i,
  output logic [DW-1:0] pa_o,
  output logic [DW-1:0] pa_oe_o,
  input  logic [DW-1:0] pb_i,
  output logic [DW-1:0] pb_o,
  output logic [DW-1:0] pb_oe_o,
  input  logic [DW-1:0] pc_i,
  output logic [DW-1:0] pc_o,
  output logic [DW-1:0] pc_oe_o
);
  localparam int unsigned NW = DW / 2;

  logic          wr_hit;
  logic          rd_hit;
  logic          ctl_we;
  logic          cfg_accept;
  logic [DW-1:0] ctl_val;
  dir_t          dir;

  assign wr_hit = cs_i & wr_i;
  assign rd_hit = cs_i & rd_i;
  assign ctl_we = wr_hit && (addr_i == REG_CTL);

  pio3_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (ctl_we),
    .wdata_i (wdata_i),
    .ctl_o   (ctl_val),
    .dir_o   (dir),
    .accept_o(cfg_accept)
  );

  // ports A and B: full-byte lanes
  logic [1:0][DW-1:0] ab_pin_i;
  logic [1:0][DW-1:0] ab_pin_o;
  logic [1:0][DW-1:0] ab_oe;
  logic [1:0][DW-1:0] ab_rd;
  logic [1:0]         ab_dir;

  assign ab_pin_i = {pb_i, pa_i};
  assign ab_dir   = {dir.pb_in, dir.pa_in};

  for (genvar g = 0; g < 2; g++) begin : g_ab
    pio3_lane #(.W(DW)) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (cfg_accept),
      .we_i    (wr_hit && (addr_i == AW'(g))),
      .wdata_i (wdata_i),
      .dir_in_i(ab_dir[g]),
      .pin_i   (ab_pin_i[g]),
      .pin_o   (ab_pin_o[g]),
      .oe_o    (ab_oe[g]),
      .rdata_o (ab_rd[g])
    );
  end

  assign pa_o    = ab_pin_o[0];
  assign pb_o    = ab_pin_o[1];
  assign pa_oe_o = ab_oe[0];
  assign pb_oe_o = ab_oe[1];

  // port C: two independently directed nibbles sharing one offset
  logic [1:0] c_dir;
  logic [DW-1:0] c_rd;

  assign c_dir = {dir.chi_in, dir.clo_in};

  for (genvar n = 0; n < 2; n++) begin : g_c
    pio3_lane #(.W(NW)) i_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (cfg_accept),
      .we_i    (wr_hit && (addr_i == REG_PC)),
      .wdata_i (wdata_i[n*NW +: NW]),
      .dir_in_i(c_dir[n]),
      .pin_i   (pc_i[n*NW +: NW]),
      .pin_o   (pc_o[n*NW +: NW]),
      .oe_o    (pc_oe_o[n*NW +: NW]),
      .rdata_o (c_rd[n*NW +: NW])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (rd_hit) begin
      unique case (reg_sel_e'(addr_i))
        REG_PA:  rdata_o = ab_rd[0];
        REG_PB:  rdata_o = ab_rd[1];
        REG_PC:  rdata_o = c_rd;
        REG_CTL: rdata_o = ctl_val;
        default: rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio3_port_chk.sv
module pio3_port_chk
  import pio3_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_i,
  input logic [AW-1:0] addr_i,
  input logic          rd_i,
  input logic          wr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] rdata_o,
  input logic [DW-1:0] pa_o,
  input logic [DW-1:0] pa_oe_o,
  input logic [DW-1:0] pb_o,
  input logic [DW-1:0] pb_oe_o,
  input logic [DW-1:0] pc_o,
  input logic [DW-1:0] pc_oe_o
);
  logic wr_hit;
  logic good_cfg;
  logic bad_cfg;

  assign wr_hit   = cs_i && wr_i;
  assign good_cfg = wr_hit && addr_i == 2'd3 && wdata_i[7] && wdata_i[6:5] == 2'b00 && !wdata_i[2];
  assign bad_cfg  = wr_hit && addr_i == 2'd3 && !good_cfg;

  AST_GOOD_CFG_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_cfg |=> pa_oe_o == {DW{~$past(wdata_i[4])}} && pb_oe_o == {DW{~$past(wdata_i[1])}}); // R3

  AST_BAD_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cfg |=> $stable(pa_oe_o) && $stable(pb_oe_o) && $stable(pc_oe_o)); // R5

  AST_CFG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    good_cfg |=> pa_o == '0 && pb_o == '0 && pc_o == '0); // R6

  AST_PA_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit && addr_i == 2'd0 |=> pa_o == $past(wdata_i)); // R7

  AST_NO_WRITE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(pa_o) && $stable(pb_o) && $stable(pc_o)); // R12

  AST_RD_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |-> rdata_o == '0); // R11

  AST_OUT_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && rd_i && addr_i == 2'd0 && pa_oe_o == '1 |-> rdata_o == pa_o); // R7

  AST_NIBBLE_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_oe_o[3:0] == 4'h0 || pc_oe_o[3:0] == 4'hF) && (pc_oe_o[7:4] == 4'h0 || pc_oe_o[7:4] == 4'hF)); // R9
endmodule

bind pio3_port pio3_port_chk i_pio3_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .cs_i   (cs_i),
  .addr_i (addr_i),
  .rd_i   (rd_i),
  .wr_i   (wr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .pa_o   (pa_o),
  .pa_oe_o(pa_oe_o),
  .pb_o   (pb_o),
  .pb_oe_o(pb_oe_o),
  .pc_o   (pc_o),
  .pc_oe_o(pc_oe_o)
);

// File: tb/test_pio3_port.sv
`timescale 1ns/1ps
module test_pio3_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic       rd_i = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] pa_i = 8'h5A, pa_o, pa_oe_o;
  logic [7:0] pb_i = 8'hC3, pb_o, pb_oe_o;
  logic [7:0] pc_i = 8'h96, pc_o, pc_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  pio3_port i_pio3_port (.*);

  task automatic chk(input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input logic sel);
    @(negedge clk_i);
    cs_i = sel; wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = a;
    #2 d = rdata_o;
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  // {req, is_write, offset, wdata, expected read}
  localparam int NV = 27;
  localparam logic [22:0] VEC [NV] = '{
    {4'd1,  1'b0, 2'd3, 8'h00, 8'h9B}, // R1 reset control
    {4'd8,  1'b0, 2'd0, 8'h00, 8'h5A}, // R8 inputs
    {4'd8,  1'b0, 2'd1, 8'h00, 8'hC3},
    {4'd8,  1'b0, 2'd2, 8'h00, 8'h96},
    {4'd3,  1'b1, 2'd3, 8'h8A, 8'h00}, // R3 A out, B in, Clo out, Chi in
    {4'd3,  1'b0, 2'd3, 8'h00, 8'h8A},
    {4'd7,  1'b1, 2'd0, 8'h3C, 8'h00}, // R7
    {4'd7,  1'b0, 2'd0, 8'h00, 8'h3C},
    {4'd9,  1'b1, 2'd2, 8'hF5, 8'h00}, // R9
    {4'd9,  1'b0, 2'd2, 8'h00, 8'h95},
    {4'd2,  1'b0, 2'd1, 8'h00, 8'hC3}, // R2
    {4'd4,  1'b1, 2'd3, 8'h0F, 8'h00}, // R4 flag clear
    {4'd4,  1'b0, 2'd3, 8'h00, 8'h8A},
    {4'd4,  1'b0, 2'd0, 8'h00, 8'h3C},
    {4'd5,  1'b1, 2'd3, 8'hA0, 8'h00}, // R5 group A strobed
    {4'd5,  1'b0, 2'd3, 8'h00, 8'h8A},
    {4'd5,  1'b1, 2'd3, 8'h84, 8'h00}, // R5 group B strobed
    {4'd5,  1'b0, 2'd3, 8'h00, 8'h8A},
    {4'd5,  1'b0, 2'd0, 8'h00, 8'h3C},
    {4'd10, 1'b1, 2'd1, 8'h77, 8'h00}, // R10 write to input B
    {4'd10, 1'b0, 2'd1, 8'h00, 8'hC3},
    {4'd6,  1'b1, 2'd3, 8'h80, 8'h00}, // R6 all outputs
    {4'd6,  1'b0, 2'd0, 8'h00, 8'h00},
    {4'd10, 1'b0, 2'd1, 8'h00, 8'h00},
    {4'd6,  1'b0, 2'd2, 8'h00, 8'h00},
    {4'd7,  1'b1, 2'd1, 8'hE1, 8'h00},
    {4'd7,  1'b0, 2'd1, 8'h00, 8'hE1}
  };

  initial begin
    logic [7:0] rv;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(1, pa_oe_o, 8'h00); // R1
    chk(1, pb_oe_o, 8'h00);
    chk(1, pc_oe_o, 8'h00);
    chk(1, pa_o | pb_o | pc_o, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) bus_wr(VEC[i][17:16], VEC[i][15:8], 1'b1);
      else begin
        bus_rd(VEC[i][17:16], rv);
        chk(int'(VEC[i][22:19]), rv, VEC[i][7:0]);
      end
    end

    // R3 all outputs after 0x80
    chk(3, pa_oe_o & pb_oe_o & pc_oe_o, 8'hFF);
    // R3 / R9 mixed configuration
    bus_wr(2'd3, 8'h8A, 1'b1);
    chk(3, pa_oe_o, 8'hFF);
    chk(3, pb_oe_o, 8'h00);
    chk(9, pc_oe_o, 8'h0F);
    bus_wr(2'd2, 8'h3C, 1'b1);
    chk(9, pc_o & pc_oe_o, 8'h0C);
    // R12 write without chip select
    bus_wr(2'd0, 8'hFF, 1'b0);
    chk(12, pa_o, 8'h00);
    bus_rd(2'd0, rv);
    chk(12, rv, 8'h00);
    // R11 idle read bus
    @(negedge clk_i);
    cs_i = 1'b1; addr_i = 2'd3; rd_i = 1'b0;
    #2 chk(11, rdata_o, 8'h00);
    cs_i = 1'b0;
    // R8 synchronizer latency on port A
    bus_wr(2'd3, 8'h90, 1'b1);
    @(negedge clk_i);
    pa_i = 8'h11;
    @(negedge clk_i);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = 2'd0;
    #2 chk(8, rdata_o, 8'h5A);
    @(negedge clk_i);
    #2 chk(8, rdata_o, 8'h11);
    cs_i = 1'b0; rd_i = 1'b0;

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule